// File: doc/BRIEF.md
# Flash Status and Write-Protect Controller

This block keeps the eight-bit status byte of a serial flash device and rules on every command the serial front end decodes. A decoder outside the block delivers one strobe per completed frame, carrying the opcode, the 18-bit array address, the first data byte and a flag that says whether the frame ended on a byte boundary with the expected byte count. The block also watches the active-low write-protect pin. One cycle after each strobe it answers with an accept or a reject pulse and updates its own state.

Accepted erase, program and status-write operations start a self-timed busy period. The length of that period is a parameter for each operation type. While it runs, the ready bit of the status byte reads busy. When it ends, the write-enable latch clears, a one-cycle notice pulse goes out, and any pending status-write bits are committed. The block also tracks a low-power state that shuts out all commands but one.

The block does not shift serial data and does not touch the memory array. Its bits that would be nonvolatile are plain registers. Their power-on values come from parameters.

Top module: `flash_status_guard`

## Requirements
- R1: `status_o` is bit 0 busy (1 = operation in progress), bit 1 write-enable latch, bit 2 protect-low, bit 3 protect-high, bits 6..4 always 0, bit 7 status lock. After reset it reads 00h with the default parameters, and `busy_o`, `pdown_o`, `cmd_accept_o` and `cmd_reject_o` are 0.
- R2: Every strobe produces exactly one of `cmd_accept_o` or `cmd_reject_o` in the next cycle. Opcode 06h sets the write-enable latch and opcode 04h clears it. Both are rejected while busy.
- R3: The write-class opcodes are 20h, D7h, D8h, C7h, 02h and 01h. Each is rejected while busy, when the latch is 0, or when `frame_ok` is 0. A rejected write leaves the latch unchanged.
- R4: Protect-high:protect-low encode the locked region: 00 none, 01 30000h–3FFFFh, 10 20000h–3FFFFh, 11 everything. The target range is the 4 KB block selected by A17..A12 for 20h/D7h, the 64 KB block selected by A17..A16 for D8h, and the 256-byte page selected by A17..A8 for 02h. A write whose range touches the locked region is rejected.
- R5: Chip erase (C7h) is accepted only when both protect bits are 0.
- R6: Status write (01h) rejects when bit 7 is 1 and `wp_n` is 0. When it is accepted, data bits 7, 3 and 2 are copied into bits 7, 3 and 2 of the status byte at the end of the busy period, and the other data bits are dropped. A frame with more than one data byte arrives with `frame_ok` = 0 and is therefore rejected.
- R7: An accepted write keeps `busy_o` high for its parameter cycle count: 20 cycles for 4 KB erase, 30 for 64 KB erase, 40 for chip erase, 12 for page program and 16 for status write. In the first idle cycle the latch reads 0 and `wen_clr_o` pulses.
- R8: Opcode 05h is accepted at any time outside power-down, including while busy.
- R9: Read opcodes 03h and 0Bh are accepted when idle, rejected while busy, and never change the latch.
- R10: Identification opcodes 9Fh and ABh are rejected while busy.
- R11: Opcode B9h sets `pdown_o` when idle. It is rejected while busy.
- R12: While `pdown_o` is 1, every opcode except ABh is rejected and changes nothing. An ABh strobe is accepted and clears `pdown_o`.
- R13: Any other opcode is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | One-cycle strobe: a decoded frame is present |
| cmd_op | input | 8 | Opcode of the frame |
| cmd_addr | input | 18 | Array address from the frame |
| cmd_wdata | input | 8 | First data byte (status write) |
| frame_ok | input | 1 | Frame ended on a byte boundary with a legal byte count |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Self-timed operation in progress |
| pdown_o | output | 1 | Power-down state |
| cmd_accept_o | output | 1 | Command accepted (one cycle after strobe) |
| cmd_reject_o | output | 1 | Command rejected (one cycle after strobe) |
| wen_clr_o | output | 1 | Pulse: latch cleared by a completed write |

## Verification
The accept or reject pulse, and any change to the latch, the lock bits or `pdown_o`, are registered on the same edge that samples the strobe. The bench drives the strobe on a falling edge and reads every result on the next falling edge. Busy rises on that same edge and stays high for exactly the parameter count. The bench counts falling edges while busy is high, and at the first idle falling edge it checks `wen_clr_o` and the committed status byte. Status-write data is checked twice: once while busy, to confirm the old bits still show, and once after completion.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [3:0] {
    K_WREN, K_WRDI, K_RDSR, K_READ, K_IDJ, K_IDAB, K_PDN,
    K_SSE, K_SE, K_CE, K_PP, K_WRSR, K_BAD
  } op_kind_e;

  function automatic op_kind_e kind_of(input logic [7:0] op);
    case (op)
      8'h06:        return K_WREN;
      8'h04:        return K_WRDI;
      8'h05:        return K_RDSR;
      8'h03, 8'h0B: return K_READ;
      8'h9F:        return K_IDJ;
      8'hAB:        return K_IDAB;
      8'hB9:        return K_PDN;
      8'h20, 8'hD7: return K_SSE;
      8'hD8:        return K_SE;
      8'hC7:        return K_CE;
      8'h02:        return K_PP;
      8'h01:        return K_WRSR;
      default:      return K_BAD;
    endcase
  endfunction

  function automatic logic is_write(input op_kind_e k);
    return (k == K_SSE) || (k == K_SE) || (k == K_CE) ||
           (k == K_PP)  || (k == K_WRSR);
  endfunction

endpackage

// File: rtl/fsg_prot_range.sv
module fsg_prot_range
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int SSEC_W = 12,
  parameter int SEC_W  = 16,
  parameter int PAGE_W = 8
) (
  input  op_kind_e            kind,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          bp,
  output logic                hit
);
  localparam logic [ADDR_W-1:0] SSE_MASK  = ADDR_W'((64'd1 << SSEC_W) - 1);
  localparam logic [ADDR_W-1:0] SE_MASK   = ADDR_W'((64'd1 << SEC_W) - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_W) - 1);

  // lowest locked address per protect level; locked regions are top-aligned
  logic [ADDR_W-1:0] low_tab [4];
  for (genvar g = 0; g < 4; g++) begin : g_lvl
    if (g == 0) begin : g_none
      assign low_tab[g] = '1;
    end else if (g == 3) begin : g_all
      assign low_tab[g] = '0;
    end else begin : g_part
      assign low_tab[g] = ADDR_W'(64'(4 - g) << (ADDR_W - 2));
    end
  end

  // since the region reaches the top, overlap reduces to: range top >= bound
  logic [ADDR_W-1:0] range_top;
  always_comb begin
    case (kind)
      K_SSE:   range_top = addr | SSE_MASK;
      K_SE:    range_top = addr | SE_MASK;
      default: range_top = addr | PAGE_MASK;
    endcase
  end

  assign hit = (bp != 2'b00) && (range_top >= low_tab[bp]);

endmodule

// File: rtl/fsg_cmd_gate.sv
module fsg_cmd_gate
  import fsg_pkg::*;
(
  input  op_kind_e kind,
  input  logic     busy,
  input  logic     pdown,
  input  logic     wen,
  input  logic     srwp,
  input  logic     wp_n,
  input  logic     frame_ok,
  input  logic     prot_hit,
  input  logic [1:0] bp,
  output logic     accept,
  output logic     start_wr
);
  logic wr_base;
  assign wr_base = !busy && wen && frame_ok;

  always_comb begin
    accept = 1'b0;
    if (pdown) begin
      accept = (kind == K_IDAB);
    end else begin
      case (kind)
        K_RDSR:                         accept = 1'b1;
        K_WREN, K_WRDI, K_READ,
        K_IDJ, K_IDAB, K_PDN:           accept = !busy;
        K_SSE, K_SE, K_PP:              accept = wr_base && !prot_hit;
        K_CE:                           accept = wr_base && (bp == 2'b00);
        K_WRSR:                         accept = wr_base && !(srwp && !wp_n);
        default:                        accept = 1'b0;
      endcase
    end
  end

  assign start_wr = accept && is_write(kind);

endmodule

// File: rtl/fsg_busy_timer.sv
module fsg_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && (cnt_q != '0) |=> busy_q);

  // R3
  no_reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy_q);

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int         ADDR_W     = 18,
  parameter int         SSE_CYC    = 20,
  parameter int         SE_CYC     = 30,
  parameter int         CE_CYC     = 40,
  parameter int         PP_CYC     = 12,
  parameter int         SRW_CYC    = 16,
  parameter logic [1:0] BP_INIT    = 2'b00,
  parameter logic       SRWP_INIT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              frame_ok,
  input  logic              wp_n,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              pdown_o,
  output logic              cmd_accept_o,
  output logic              cmd_reject_o,
  output logic              wen_clr_o
);
  localparam int MAX_A   = (SSE_CYC > SE_CYC) ? SSE_CYC : SE_CYC;
  localparam int MAX_B   = (CE_CYC > PP_CYC) ? CE_CYC : PP_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_AB > SRW_CYC) ? MAX_AB : SRW_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  op_kind_e kind;
  assign kind = kind_of(cmd_op);

  logic       wen_q, srwp_q, pdown_q, acc_q, rej_q, clr_q;
  logic [1:0] bp_q;
  logic       pend_q, pend_srwp_q;
  logic [1:0] pend_bp_q;
  logic       busy, expire, prot_hit, accept, start_wr;
  logic [CNT_W-1:0] load_val;

  fsg_prot_range #(.ADDR_W(ADDR_W)) u_prot (
    .kind(kind), .addr(cmd_addr), .bp(bp_q), .hit(prot_hit)
  );

  fsg_cmd_gate u_gate (
    .kind(kind), .busy(busy), .pdown(pdown_q), .wen(wen_q), .srwp(srwp_q),
    .wp_n(wp_n), .frame_ok(frame_ok), .prot_hit(prot_hit), .bp(bp_q),
    .accept(accept), .start_wr(start_wr)
  );

  always_comb begin
    case (kind)
      K_SSE:   load_val = CNT_W'(SSE_CYC - 1);
      K_SE:    load_val = CNT_W'(SE_CYC - 1);
      K_CE:    load_val = CNT_W'(CE_CYC - 1);
      K_PP:    load_val = CNT_W'(PP_CYC - 1);
      default: load_val = CNT_W'(SRW_CYC - 1);
    endcase
  end

  fsg_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(cmd_stb && start_wr), .load_val(load_val),
    .busy(busy), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q       <= 1'b0;
      bp_q        <= BP_INIT;
      srwp_q      <= SRWP_INIT;
      pdown_q     <= 1'b0;
      acc_q       <= 1'b0;
      rej_q       <= 1'b0;
      clr_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_srwp_q <= 1'b0;
      pend_bp_q   <= 2'b00;
    end else begin
      acc_q <= cmd_stb && accept;
      rej_q <= cmd_stb && !accept;
      clr_q <= expire;
      if (expire) begin
        wen_q <= 1'b0;
        if (pend_q) begin
          srwp_q <= pend_srwp_q;
          bp_q   <= pend_bp_q;
          pend_q <= 1'b0;
        end
      end
      if (cmd_stb && accept) begin
        case (kind)
          K_WREN: wen_q   <= 1'b1;
          K_WRDI: wen_q   <= 1'b0;
          K_PDN:  pdown_q <= 1'b1;
          K_IDAB: pdown_q <= 1'b0;
          K_WRSR: begin
            pend_q      <= 1'b1;
            pend_srwp_q <= cmd_wdata[7];
            pend_bp_q   <= cmd_wdata[3:2];
          end
          default: ;
        endcase
      end
    end
  end

  assign status_o     = {srwp_q, 3'b000, bp_q, wen_q, busy};
  assign busy_o       = busy;
  assign pdown_o      = pdown_q;
  assign cmd_accept_o = acc_q;
  assign cmd_reject_o = rej_q;
  assign wen_clr_o    = clr_q;

  // R2
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> (cmd_accept_o ^ cmd_reject_o));

  // R3
  wen_needed_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb && is_write(kind) && !wen_q |=> cmd_reject_o && !wen_q);

  // R5
  ce_guard_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb && (kind == K_CE) && (bp_q != 2'b00) |=> cmd_reject_o);

  // R7
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wen_q && wen_clr_o);

  // R8
  rdsr_open_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb && !pdown_q && (cmd_op == 8'h05) |=> cmd_accept_o);

  // R12
  pdown_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb && pdown_q && (cmd_op != 8'hAB) |=> cmd_reject_o && pdown_o && $stable(wen_q));

endmodule

// File: tb/flash_status_guard_bench.sv
module flash_status_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_stb = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [17:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        frame_ok = 1'b1;
  logic        wp_n = 1'b1;
  logic [7:0]  status_o;
  logic        busy_o, pdown_o, cmd_accept_o, cmd_reject_o, wen_clr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_guard u_flash_status_guard (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .frame_ok(frame_ok),
    .wp_n(wp_n), .status_o(status_o), .busy_o(busy_o), .pdown_o(pdown_o),
    .cmd_accept_o(cmd_accept_o), .cmd_reject_o(cmd_reject_o),
    .wen_clr_o(wen_clr_o)
  );

  task automatic expect_v(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // strobe one frame and check the answer on the next falling edge
  task automatic exec(string tag, logic [7:0] op, logic [17:0] a,
                      logic [7:0] d, logic fok, logic exp_acc);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; frame_ok = fok;
    @(negedge clk);
    cmd_stb = 1'b0; frame_ok = 1'b1;
    expect_v({tag, " accept"}, int'(cmd_accept_o), int'(exp_acc));
    expect_v({tag, " reject"}, int'(cmd_reject_o), int'(!exp_acc));
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic wait_done(string tag, int exp_n);
    int n = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    expect_v({tag, " busy cycles"}, n, exp_n);
    expect_v({tag, " wen_clr pulse"}, int'(wen_clr_o), 1);
    expect_v({tag, " latch cleared"}, int'(status_o[1]), 0);
  endtask

  task automatic t_reset();
    expect_v("R1 status after reset", status_o, 8'h00);
    expect_v("R1 busy after reset", busy_o, 0);
    expect_v("R1 pdown after reset", pdown_o, 0);
    expect_v("R1 accept after reset", cmd_accept_o, 0);
    expect_v("R1 reject after reset", cmd_reject_o, 0);
  endtask

  task automatic t_latch();
    exec("R2 set latch", 8'h06, 0, 0, 1, 1);
    expect_v("R2 status after 06h", status_o, 8'h02);
    exec("R2 clear latch", 8'h04, 0, 0, 1, 1);
    expect_v("R2 status after 04h", status_o, 8'h00);
    exec("R13 unknown opcode", 8'h5A, 0, 0, 1, 0);
    expect_v("R13 status unchanged", status_o, 8'h00);
  endtask

  task automatic t_write_rules();
    exec("R3 erase without latch", 8'h20, 0, 0, 1, 0);
    expect_v("R3 still idle", busy_o, 0);
    exec("R3 latch", 8'h06, 0, 0, 1, 1);
    exec("R3 malformed program", 8'h02, 18'h00100, 0, 0, 0);
    expect_v("R3 latch kept", status_o, 8'h02);
    exec("R7 small erase", 8'h20, 18'h01234, 0, 1, 1);
    wait_done("R7 small erase", 20);
    expect_v("R7 status after erase", status_o, 8'h00);
  endtask

  task automatic t_status_write();
    exec("R6 latch", 8'h06, 0, 0, 1, 1);
    exec("R6 status write", 8'h01, 0, 8'h8F, 1, 1);
    expect_v("R6 old bits while busy", status_o, 8'h03);
    exec("R8 status read busy", 8'h05, 0, 0, 1, 1);
    exec("R2 latch while busy", 8'h06, 0, 0, 1, 0);
    exec("R9 read while busy", 8'h03, 0, 0, 1, 0);
    exec("R10 id 9Fh while busy", 8'h9F, 0, 0, 1, 0);
    exec("R10 id ABh while busy", 8'hAB, 0, 0, 1, 0);
    exec("R11 sleep while busy", 8'hB9, 0, 0, 1, 0);
    expect_v("R11 no pdown", pdown_o, 0);
    wait_idle();
    expect_v("R6 committed bits", status_o, 8'h8C);
  endtask

  task automatic t_protect();
    exec("R4 latch", 8'h06, 0, 0, 1, 1);
    exec("R4 program all-locked", 8'h02, 18'h00000, 0, 1, 0);
    expect_v("R4 latch kept", status_o, 8'h8E);
    wp_n = 1'b0;
    exec("R6 locked by pin", 8'h01, 0, 8'h00, 1, 0);
    expect_v("R6 bits kept", status_o, 8'h8E);
    wp_n = 1'b1;
    exec("R6 pin high unlocks", 8'h01, 0, 8'h04, 1, 1);
    wait_idle();
    expect_v("R6 level 1 set", status_o, 8'h04);
    exec("R4 latch", 8'h06, 0, 0, 1, 1);
    exec("R4 64K below quarter", 8'hD8, 18'h2ABCD, 0, 1, 1);
    wait_idle();
    exec("R4 latch", 8'h06, 0, 0, 1, 1);
    exec("R4 64K in quarter", 8'hD8, 18'h30000, 0, 1, 0);
    exec("R4 4K below quarter", 8'hD7, 18'h2F123, 0, 1, 1);
    wait_idle();
    exec("R4 latch", 8'h06, 0, 0, 1, 1);
    exec("R4 last free page", 8'h02, 18'h2FFFF, 0, 1, 1);
    wait_idle();
    exec("R4 latch", 8'h06, 0, 0, 1, 1);
    exec("R5 chip erase locked", 8'hC7, 0, 0, 1, 0);
    exec("R4 page in quarter", 8'h02, 18'h30000, 0, 1, 0);
    expect_v("R4 latch kept lvl1", status_o, 8'h06);
    exec("R6 level 2", 8'h01, 0, 8'h08, 1, 1);
    wait_idle();
    expect_v("R6 level 2 set", status_o, 8'h08);
    exec("R4 latch", 8'h06, 0, 0, 1, 1);
    exec("R4 4K in half", 8'h20, 18'h20000, 0, 1, 0);
    exec("R4 64K below half", 8'hD8, 18'h1FFFF, 0, 1, 1);
    wait_done("R4 64K erase", 30);
    exec("R6 latch", 8'h06, 0, 0, 1, 1);
    exec("R6 level 0", 8'h01, 0, 8'h00, 1, 1);
    wait_done("R6 status write", 16);
    exec("R5 latch", 8'h06, 0, 0, 1, 1);
    exec("R5 chip erase open", 8'hC7, 0, 0, 1, 1);
    wait_done("R5 chip erase", 40);
    expect_v("R5 status after chip erase", status_o, 8'h00);
  endtask

  task automatic t_read_sleep();
    exec("R9 latch", 8'h06, 0, 0, 1, 1);
    exec("R9 read 03h", 8'h03, 18'h00010, 0, 1, 1);
    exec("R9 read 0Bh", 8'h0B, 18'h00020, 0, 1, 1);
    expect_v("R9 latch unchanged", status_o, 8'h02);
    exec("R9 clear", 8'h04, 0, 0, 1, 1);
    exec("R11 sleep", 8'hB9, 0, 0, 1, 1);
    expect_v("R11 pdown set", pdown_o, 1);
    exec("R12 status read asleep", 8'h05, 0, 0, 1, 0);
    exec("R12 latch asleep", 8'h06, 0, 0, 1, 0);
    expect_v("R12 latch untouched", status_o, 8'h00);
    exec("R12 id 9Fh asleep", 8'h9F, 0, 0, 1, 0);
    expect_v("R12 still asleep", pdown_o, 1);
    exec("R12 wake ABh", 8'hAB, 0, 0, 1, 1);
    expect_v("R12 pdown cleared", pdown_o, 0);
    exec("R8 status read awake", 8'h05, 0, 0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_write_rules();
    t_status_write();
    t_protect();
    t_read_sleep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule